// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block turns a reference clock into one pulse-width-modulated output meant to drive a display backlight. A byte-wide register interface holds an 8-bit prescaler divisor, a 16-bit period scale and a 16-bit level. The prescaler cuts the reference clock into ticks. The scale sets how many ticks make up one period, and one extra reference cycle closes each period. The level sets how many ticks the output stays active. An enable bit and an invert bit shape the final waveform.

The waveform reaches the shared general-purpose pad only when that pad's 2-bit function field selects the special function. Otherwise the pad is left undriven. Multi-byte values are written one byte per access, and no atomic update is made across bytes. A new divisor or scale takes effect at the next period boundary. The level is compared live.

Top module: `blpwm_top`

## Requirements
- R1: The output period is P×S+1 reference cycles, where P is the effective divisor (byte 0xA0) and S is the scale (0xA1 low byte, 0xA2 high byte).
- R2: While 0 < L < S, the active time in each period is L×P reference cycles. L is the level (0xA3 low byte, 0xA4 high byte).
- R3: A divisor value of 0 behaves exactly like a divisor of 1.
- R4: When L ≥ S and L ≠ 0, the output is active for the whole period. When L = 0, the output is never active.
- R5: Bit 0 of the control byte (0xA5), when set, inverts the output after the R4 rules are applied.
- R6: When bit 1 of the control byte (enable) is 0, the counters hold at zero and the output sits at the level of the invert bit.
- R7: The pad is driven (padOe=1, padOut equal to the waveform) only when bits [7:6] of the pad-function byte (0x5C) equal 2'b10. Any other field value gives padOe=0 and padOut=0.
- R8: During and straight after reset, every register reads 0 and the pad is undriven.
- R9: A read returns the last byte written to that address. Unmapped addresses read 0. Reads have no side effects.
- R10: A new divisor or scale value is taken up only at the next period boundary, so the period in progress keeps its old length. A new level value affects the period in progress at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr (combinational) |
| padOut | output | 1 | Pad output value |
| padOe | output | 1 | Pad output enable |

## Verification
The hardest behaviour to reach from the ports is the period-boundary handover of R10. A scale or level write must land inside a period that is already running, and the length of that period must then be seen unchanged. The bench waits for a rising output edge. In that same sample slot it starts a byte write, so the write commits one cycle into the period. It then counts samples up to the next rising edge, which gives the old period length. For the level, it counts the active run, which must shrink at once.

// File: rtl/blpwm_pkg.sv
package blpwm_pkg;
  // strobes from register/control side to the counting datapath
  typedef struct packed {
    logic run;
    logic invert;
    logic pinSel;
  } pwmCtl_t;

  localparam logic [1:0] PIN_FN_SPECIAL = 2'b10;
endpackage

// File: rtl/blpwm_ctrl.sv
module blpwm_ctrl
  import blpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W = 8,
  parameter int SCALE_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hA0,
  parameter logic [ADDR_W-1:0] GPIO_ADDR = 8'h5C,
  parameter int PIN_IDX = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  output logic [PRE_W-1:0]   preDiv,
  output logic [SCALE_W-1:0] scaleVal,
  output logic [SCALE_W-1:0] levelVal,
  output pwmCtl_t            ctl
);
  localparam int SB = SCALE_W / 8;
  localparam int MUX_LSB = 2 * PIN_IDX;
  localparam logic [ADDR_W-1:0] SCALE_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LEVEL_ADDR = SCALE_ADDR + ADDR_W'(SB);
  localparam logic [ADDR_W-1:0] CTL_ADDR = LEVEL_ADDR + ADDR_W'(SB);

  logic [PRE_W-1:0] preReg;
  logic [7:0] scaleB [SB];
  logic [7:0] levelB [SB];
  logic [7:0] ctlReg;
  logic [7:0] gpioReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preReg  <= '0;
      ctlReg  <= '0;
      gpioReg <= '0;
      for (int i = 0; i < SB; i++) begin
        scaleB[i] <= '0;
        levelB[i] <= '0;
      end
    end else if (regWe) begin
      if (regAddr == BASE_ADDR) preReg <= regWdata[PRE_W-1:0];
      if (regAddr == CTL_ADDR) ctlReg <= regWdata;
      if (regAddr == GPIO_ADDR) gpioReg <= regWdata;
      for (int i = 0; i < SB; i++) begin
        if (regAddr == SCALE_ADDR + ADDR_W'(i)) scaleB[i] <= regWdata;
        if (regAddr == LEVEL_ADDR + ADDR_W'(i)) levelB[i] <= regWdata;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == BASE_ADDR) regRdata = 8'(preReg);
    if (regAddr == CTL_ADDR) regRdata = ctlReg;
    if (regAddr == GPIO_ADDR) regRdata = gpioReg;
    for (int i = 0; i < SB; i++) begin
      if (regAddr == SCALE_ADDR + ADDR_W'(i)) regRdata = scaleB[i];
      if (regAddr == LEVEL_ADDR + ADDR_W'(i)) regRdata = levelB[i];
    end
  end

  always_comb begin
    for (int i = 0; i < SB; i++) begin
      scaleVal[i*8 +: 8] = scaleB[i];
      levelVal[i*8 +: 8] = levelB[i];
    end
  end

  assign preDiv     = preReg;
  assign ctl.run    = ctlReg[1];
  assign ctl.invert = ctlReg[0];
  assign ctl.pinSel = (gpioReg[MUX_LSB +: 2] == PIN_FN_SPECIAL);

  // R6: a control write is seen by the datapath on the following cycle
  a_r6_run_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CTL_ADDR) |=> (ctl.run == $past(regWdata[1])));

  // R7: pad select changes only through a write to the pad-function byte
  a_r7_pinsel_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == GPIO_ADDR) |=> $stable(ctl.pinSel));
endmodule

// File: rtl/blpwm_datapath.sv
module blpwm_datapath
  import blpwm_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SCALE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PRE_W-1:0]   preDiv,
  input  logic [SCALE_W-1:0] scaleVal,
  input  logic [SCALE_W-1:0] levelVal,
  input  pwmCtl_t            ctl,
  output logic               padOut,
  output logic               padOe
);
  logic [PRE_W-1:0]   effPre;
  logic [PRE_W-1:0]   actPre;
  logic [PRE_W-1:0]   preCnt;
  logic [SCALE_W-1:0] actScale;
  logic [SCALE_W-1:0] tickCnt;
  logic               inTail;
  logic               rawActive;
  logic               pwmWave;

  assign effPre = (preDiv == '0) ? PRE_W'(1) : preDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPre   <= PRE_W'(1);
      actScale <= '0;
      preCnt   <= '0;
      tickCnt  <= '0;
      inTail   <= 1'b0;
    end else if (!ctl.run || inTail) begin
      // period boundary (or idle): take up new divisor and scale
      actPre   <= effPre;
      actScale <= scaleVal;
      preCnt   <= '0;
      tickCnt  <= '0;
      inTail   <= (scaleVal == '0);
    end else if (preCnt == actPre - PRE_W'(1)) begin
      preCnt <= '0;
      if (tickCnt == actScale - SCALE_W'(1)) begin
        tickCnt <= '0;
        inTail  <= 1'b1;
      end else begin
        tickCnt <= tickCnt + SCALE_W'(1);
      end
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    if (levelVal == '0)            rawActive = 1'b0;
    else if (levelVal >= actScale) rawActive = 1'b1;
    else if (inTail)               rawActive = 1'b0;
    else                           rawActive = (tickCnt < levelVal);
  end

  assign pwmWave = ctl.run ? (rawActive ^ ctl.invert) : ctl.invert;
  assign padOe   = ctl.pinSel;
  assign padOut  = ctl.pinSel & pwmWave;

  // R6: counters sit at zero after a disabled cycle
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (tickCnt == '0 && preCnt == '0));

  // R3: active divisor never zero, so counting never stalls
  a_r3_pre_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    actPre != '0);

  // R1: tick index stays inside the sampled scale outside the tail cycle
  a_r1_tick_bound: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.run && !inTail) |-> (tickCnt < actScale && preCnt < actPre));

  // R10: sampled scale only changes at a boundary
  a_r10_scale_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.run) && !$past(inTail)) |-> $stable(actScale));
endmodule

// File: rtl/blpwm_top.sv
module blpwm_top
  import blpwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PRE_W = 8,
  parameter int SCALE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              padOut,
  output logic              padOe
);
  logic [PRE_W-1:0]   preDiv;
  logic [SCALE_W-1:0] scaleVal;
  logic [SCALE_W-1:0] levelVal;
  pwmCtl_t            ctl;

  blpwm_ctrl #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .SCALE_W(SCALE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .preDiv(preDiv),
    .scaleVal(scaleVal), .levelVal(levelVal), .ctl(ctl)
  );

  blpwm_datapath #(.PRE_W(PRE_W), .SCALE_W(SCALE_W)) i_datapath (
    .clk(clk), .rstN(rstN), .preDiv(preDiv), .scaleVal(scaleVal),
    .levelVal(levelVal), .ctl(ctl), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: tb/test_blpwm_top.sv
module test_blpwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // pre, scale, level, ctl, expected padOut high run, expected low run
  localparam int VEC [NVEC][6] = '{
    '{2, 5, 2, 2, 4, 7},
    '{1, 4, 1, 2, 1, 4},
    '{3, 3, 1, 2, 3, 7},
    '{0, 6, 3, 2, 3, 4},
    '{4, 2, 1, 2, 4, 5},
    '{2, 4, 3, 3, 3, 6}
  };

  logic clk = 0;
  logic rstN = 0;
  logic regWe = 0;
  logic [7:0] regAddr = 0;
  logic [7:0] regWdata = 0;
  logic [7:0] regRdata;
  logic padOut, padOe;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  blpwm_top i_blpwm_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padOut(padOut), .padOe(padOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rdCheck(input logic [7:0] a, input int exp, input string req);
    regAddr = a;
    #1;
    check(regRdata == 8'(exp), req, regRdata, exp);
  endtask

  task automatic cfg(input int pre, input int sc, input int lv, input int c);
    wr(8'hA5, 0);
    wr(8'hA0, 8'(pre));
    wr(8'hA1, 8'(sc)); wr(8'hA2, 8'(sc >> 8));
    wr(8'hA3, 8'(lv)); wr(8'hA4, 8'(lv >> 8));
    wr(8'hA5, 8'(c));
  endtask

  task automatic waitRise();
    logic prev;
    prev = padOut;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!prev && padOut) return;
      prev = padOut;
    end
  endtask

  task automatic runLens(output int hi, output int lo);
    waitRise();
    hi = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!padOut) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (padOut) break;
      lo++;
    end
  endtask

  task automatic constFor(input int n, input logic exp, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (padOut !== exp) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, lo, n;
    // R8: reset state
    repeat (3) @(negedge clk);
    check(padOe == 0 && padOut == 0, "R8 pad undriven in reset", padOe, 0);
    rstN = 1;
    @(negedge clk);
    rdCheck(8'hA5, 0, "R8 control after reset");
    rdCheck(8'hA1, 0, "R8 scale after reset");
    check(padOe == 0, "R8 pad undriven after reset", padOe, 0);

    // R9: readback
    wr(8'hA1, 8'h34); wr(8'hA2, 8'h12); wr(8'hA4, 8'h56);
    rdCheck(8'hA1, 8'h34, "R9 readback scale low");
    rdCheck(8'hA2, 8'h12, "R9 readback scale high");
    rdCheck(8'hA4, 8'h56, "R9 readback level high");
    rdCheck(8'hA1, 8'h34, "R9 read no side effect");
    rdCheck(8'h77, 0, "R9 unmapped reads zero");

    // R7: pad function not special
    wr(8'h5C, 8'h40);
    cfg(1, 4, 9, 2);
    constFor(20, 1'b0, "R7 pad low when not selected");
    check(padOe == 0, "R7 padOe off when not selected", padOe, 0);
    wr(8'h5C, 8'h80);
    rdCheck(8'h5C, 8'h80, "R9 readback pad function");
    check(padOe == 1, "R7 padOe on when special", padOe, 1);
    constFor(20, 1'b1, "R4 full active when level>=scale");

    // vector table: R1 R2 R3 R5
    for (int v = 0; v < NVEC; v++) begin
      cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      runLens(hi, lo);
      runLens(hi, lo);
      check(hi == VEC[v][4], $sformatf("R2/R5 high run vec%0d", v), hi, VEC[v][4]);
      check(hi + lo == VEC[v][4] + VEC[v][5], $sformatf("R1/R3 period vec%0d", v), hi + lo, VEC[v][4] + VEC[v][5]);
    end

    // R4 and R5 on fixed levels
    cfg(2, 5, 0, 2);
    constFor(40, 1'b0, "R4 level zero never active");
    cfg(2, 5, 0, 3);
    constFor(40, 1'b1, "R5 level zero inverted");
    cfg(2, 5, 5, 3);
    constFor(40, 1'b0, "R5 full level inverted");

    // R6: disabled idle level
    cfg(1, 4, 2, 1);
    constFor(30, 1'b1, "R6 disabled idle with invert");
    cfg(1, 4, 2, 0);
    constFor(30, 1'b0, "R6 disabled idle no invert");

    // R10: scale change mid-period
    cfg(1, 10, 3, 2);
    runLens(hi, lo);
    waitRise();
    regAddr = 8'hA1; regWdata = 8'd5; regWe = 1;
    n = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regWe = 0;
      if (padOut) begin
        n++;
        continue;
      end
      break;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (padOut) break;
      n++;
    end
    n++;
    check(n == 11, "R10 running period keeps old scale", n, 11);
    runLens(hi, lo);
    check(hi + lo == 6, "R10 new scale at next period", hi + lo, 6);

    // R10: level is live
    waitRise();
    regAddr = 8'hA3; regWdata = 8'd1; regWe = 1;
    hi = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      regWe = 0;
      if (!padOut) break;
      hi++;
    end
    check(hi == 1, "R10 level applies at once", hi, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule